// File: doc/BRIEF.md
# ADPCM Sample Buffer Host Interface

This block sits between a host processor and the sample memory that feeds an ADPCM decoder. The host reaches it through one byte-wide bus with four targets: the low and high bytes of a 16-bit address register, a command register, and a data port for programmed reads and writes of the sample memory. A second input takes streamed bytes from a DMA source and writes them straight into the memory.

The block keeps a read pointer and a write pointer, each 16 bits wide and wrapping modulo 65536. The memory itself is indexed by the low `RAM_AW` bits of these pointers. When a command loads a pointer, the block also arms a small count of discarded accesses. Until that count reaches zero, each data-port access only decrements it, and two busy bits in the status byte follow the count.

Toward the playback sequencer, the block exports:
- the playback length;
- the repeat and play bits of the last command;
- the playback start pointer;
- a one-cycle strobe for every command write;
- a one-cycle controller-reset strobe, which tells the sequencer to lower its half-way and end flags.

Top module: `adpcm_host_if`

## Requirements
- R1: After the synchronous reset, the status byte is 0x01 and `rd_valid`, `cmd_strobe`, `seq_reset`, `repeat_mode` and `play_req` are 0. `play_len`, `play_start_ptr` and `cmd_bits` are 0, and both pointers and both pending counts are 0.
- R2: A host write with `host_sel` = 0 loads the low byte of the address register, and `host_sel` = 1 loads the high byte. `host_sel` = 2 writes the command register and `host_sel` = 3 selects the data port.
- R3: Command bit 1 loads the write pointer from the address register. With command bit 0 = 0 one discarded write is armed; with bit 0 = 1 none is armed. Status bit 2 is 1 exactly while that count is nonzero.
- R4: Command bit 3 loads the read pointer from the address register. With command bit 2 = 0 two discarded reads are armed; with bit 2 = 1 one is armed. Status bit 7 is 1 exactly while that count is nonzero.
- R5: A data-port access made while its pending count is nonzero only decrements that count. A write stores nothing. A read gives `rd_valid` one cycle later with `rd_data` = 0x00, and the pointer does not move.
- R6: A data-port access with a zero pending count acts on the byte at the pointer and then increments the pointer modulo 65536, so 0xFFFF is followed by 0x0000. A read returns that byte on `rd_data`, with `rd_valid`, one cycle after the request.
- R7: Command bit 4 copies the address register into `play_len`. While bit 4 of the last command is set, every address-byte write also copies the new address value into `play_len`.
- R8: `repeat_mode` follows command bit 5 and `play_req` follows command bit 6 of the last command. Status bit 3 (playing) equals `play_req`, and status bit 0 (stopped) is always its inverse. A command with bit 6 set captures the read pointer into `play_start_ptr`, taking the newly loaded value when bit 3 is set in the same command.
- R9: Command bit 7 clears both pointers, both pending counts and `play_start_ptr`, and pulses `seq_reset` for one cycle. Pointer loads in the same command take effect after the clear.
- R10: Each DMA byte is stored at the write pointer, the write pointer increments modulo 65536, and the write pending count clears.
- R11: A DMA byte that arrives in the same cycle as a write-pointer load is stored at the pointer value before the load. The load then sets the pointer and the pending count.
- R12: A host data-port write in the same cycle as a DMA byte is discarded. It stores nothing, moves no pointer and leaves the pending count untouched.
- R13: Every command write pulses `cmd_strobe` for exactly one cycle, starting the cycle after the write, and `cmd_bits` then holds the written command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host data-port read strobe (with `host_sel` = 3) |
| host_sel | input | 2 | Host target: 0 address low, 1 address high, 2 command, 3 data |
| host_wdata | input | 8 | Host write byte |
| dma_valid | input | 1 | DMA byte present this cycle |
| dma_data | input | 8 | DMA byte |
| rd_valid | output | 1 | Read result valid, one cycle after a data-port read |
| rd_data | output | 8 | Read result (0x00 for a discarded read) |
| status | output | 8 | Bit 7 read pending, bit 3 playing, bit 2 write pending, bit 0 stopped |
| play_len | output | 16 | Playback length |
| repeat_mode | output | 1 | Repeat bit of the last command |
| play_req | output | 1 | Play bit of the last command |
| play_start_ptr | output | 16 | Playback start pointer |
| cmd_bits | output | 8 | Last command byte |
| cmd_strobe | output | 1 | One-cycle pulse after a command write |
| seq_reset | output | 1 | One-cycle pulse after a controller-reset command |

## Verification
Two pairs of actions can share a cycle:
- a DMA byte with a command that reloads the write pointer;
- a DMA byte with a host data-port write.

The bench drives both inputs on the same falling edge. It judges the result by reading the memory back through the data port after repositioning the read pointer. It also checks status bit 2 immediately after the shared cycle.

For the first pair, the streamed byte must appear at the old pointer and the new pointer must receive the next byte. For the second pair, only the DMA byte may land. A following host write must then go to the next address, not behind a consumed pending slot.

// File: rtl/adpcm_host_pkg.sv
package adpcm_host_pkg;

    localparam int PTR_W  = 16;
    localparam int BYTE_W = 8;
    localparam int PEND_W = 2;

    localparam int ST_RD_PEND = 7;
    localparam int ST_PLAYING = 3;
    localparam int ST_WR_PEND = 2;
    localparam int ST_STOPPED = 0;

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_CMD     = 2'd2,
        SEL_DATA    = 2'd3
    } host_sel_e;

    // Command byte, MSB first.
    typedef struct packed {
        logic ctl_reset;
        logic play;
        logic rpt;
        logic len_load;
        logic rd_load;
        logic rd_short;
        logic wr_load;
        logic wr_skip;
    } cmd_t;

    function automatic logic [PEND_W-1:0] wr_arm_count(input cmd_t c);
        return c.wr_skip ? PEND_W'(0) : PEND_W'(1);
    endfunction

    function automatic logic [PEND_W-1:0] rd_arm_count(input cmd_t c);
        return c.rd_short ? PEND_W'(1) : PEND_W'(2);
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input logic rd_p,
                                                      input logic wr_p,
                                                      input logic playing);
        logic [BYTE_W-1:0] s;
        s             = '0;
        s[ST_RD_PEND] = rd_p;
        s[ST_PLAYING] = playing;
        s[ST_WR_PEND] = wr_p;
        s[ST_STOPPED] = ~playing;
        return s;
    endfunction

endpackage

// File: rtl/adpcm_ptr_unit.sv
module adpcm_ptr_unit
    import adpcm_host_pkg::*;
#(
    parameter int AW = PTR_W,
    parameter int CW = PEND_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic [CW-1:0] ld_arm,
    input  logic          clr,
    input  logic          acc,
    input  logic          adv,
    output logic [AW-1:0] ptr,
    output logic [CW-1:0] pend,
    output logic          hit
);

    logic pend_zero;
    assign pend_zero = (pend == '0);
    // A real (non-discarded) access this cycle.
    assign hit = acc && pend_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= '0;
            pend <= '0;
        end else if (ld) begin
            ptr  <= ld_val;
            pend <= ld_arm;
        end else if (clr) begin
            ptr  <= '0;
            pend <= '0;
        end else if (adv) begin
            ptr  <= ptr + AW'(1);
            pend <= '0;
        end else if (acc) begin
            if (pend_zero) ptr <= ptr + AW'(1);
            else           pend <= pend - CW'(1);
        end
    end

endmodule

// File: rtl/adpcm_sample_ram.sv
module adpcm_sample_ram
    import adpcm_host_pkg::*;
#(
    parameter int PW = PTR_W,
    parameter int AW = 10,
    parameter int DW = BYTE_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [PW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] widx;
    logic [AW-1:0] ridx;

    assign widx = waddr[AW-1:0];
    assign ridx = raddr[AW-1:0];

    generate
        if (AW < PW) begin : g_alias
            logic unused_hi_bits;
            assign unused_hi_bits = ^{waddr[PW-1:AW], raddr[PW-1:AW]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
        if (re) rdata <= mem[ridx];
    end

endmodule

// File: rtl/adpcm_cmd_regs.sv
module adpcm_cmd_regs
    import adpcm_host_pkg::*;
#(
    parameter int AW = PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  host_sel_e         sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [AW-1:0]     rptr,
    output logic              cmd_fire,
    output cmd_t              cmd_now,
    output cmd_t              cmd_q,
    output logic [AW-1:0]     addr_reg,
    output logic [AW-1:0]     play_len,
    output logic [AW-1:0]     play_start,
    output logic              cmd_strobe,
    output logic              seq_reset
);

    logic          lo_we;
    logic          hi_we;
    logic [AW-1:0] addr_next;

    assign lo_we    = host_we && (sel == SEL_ADDR_LO);
    assign hi_we    = host_we && (sel == SEL_ADDR_HI);
    assign cmd_fire = host_we && (sel == SEL_CMD);
    assign cmd_now  = cmd_t'(wdata);

    always_comb begin
        addr_next = addr_reg;
        if (lo_we) addr_next[BYTE_W-1:0]  = wdata;
        if (hi_we) addr_next[AW-1:BYTE_W] = wdata[AW-BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_reg   <= '0;
            cmd_q      <= '0;
            play_len   <= '0;
            play_start <= '0;
            cmd_strobe <= 1'b0;
            seq_reset  <= 1'b0;
        end else begin
            cmd_strobe <= cmd_fire;
            seq_reset  <= cmd_fire && cmd_now.ctl_reset;
            if (lo_we || hi_we) begin
                addr_reg <= addr_next;
                if (cmd_q.len_load) play_len <= addr_next;
            end
            if (cmd_fire) begin
                cmd_q <= cmd_now;
                if (cmd_now.len_load) play_len <= addr_reg;
                if (cmd_now.play) begin
                    if (cmd_now.rd_load)        play_start <= addr_reg;
                    else if (cmd_now.ctl_reset) play_start <= '0;
                    else                        play_start <= rptr;
                end else if (cmd_now.ctl_reset) begin
                    play_start <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/adpcm_host_if.sv
module adpcm_host_if
    import adpcm_host_pkg::*;
#(
    parameter int RAM_AW = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [1:0]        host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              dma_valid,
    input  logic [BYTE_W-1:0] dma_data,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] status,
    output logic [PTR_W-1:0]  play_len,
    output logic              repeat_mode,
    output logic              play_req,
    output logic [PTR_W-1:0]  play_start_ptr,
    output logic [BYTE_W-1:0] cmd_bits,
    output logic              cmd_strobe,
    output logic              seq_reset
);

    host_sel_e          sel;
    logic               cmd_fire;
    cmd_t               cmd_now;
    cmd_t               cmd_q;
    logic [PTR_W-1:0]   addr_reg;
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [PEND_W-1:0]  wr_pend;
    logic [PEND_W-1:0]  rd_pend;
    logic               wr_hit;
    logic               rd_hit;
    logic               host_wr_acc;
    logic               host_rd_acc;
    logic               ctl_clear;
    logic               ram_we;
    logic [BYTE_W-1:0]  ram_wdata;
    logic [BYTE_W-1:0]  ram_q;
    logic               rd_dummy_q;

    assign sel         = host_sel_e'(host_sel);
    // DMA owns the write port; a colliding host write is dropped (R12).
    assign host_wr_acc = host_we && (sel == SEL_DATA) && !dma_valid;
    assign host_rd_acc = host_re && (sel == SEL_DATA);
    assign ctl_clear   = cmd_fire && cmd_now.ctl_reset;

    adpcm_cmd_regs #(.AW(PTR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .sel        (sel),
        .wdata      (host_wdata),
        .rptr       (rd_ptr),
        .cmd_fire   (cmd_fire),
        .cmd_now    (cmd_now),
        .cmd_q      (cmd_q),
        .addr_reg   (addr_reg),
        .play_len   (play_len),
        .play_start (play_start_ptr),
        .cmd_strobe (cmd_strobe),
        .seq_reset  (seq_reset)
    );

    adpcm_ptr_unit #(.AW(PTR_W), .CW(PEND_W)) u_wptr (
        .clk    (clk),
        .rst    (rst),
        .ld     (cmd_fire && cmd_now.wr_load),
        .ld_val (addr_reg),
        .ld_arm (wr_arm_count(cmd_now)),
        .clr    (ctl_clear),
        .acc    (host_wr_acc),
        .adv    (dma_valid),
        .ptr    (wr_ptr),
        .pend   (wr_pend),
        .hit    (wr_hit)
    );

    adpcm_ptr_unit #(.AW(PTR_W), .CW(PEND_W)) u_rptr (
        .clk    (clk),
        .rst    (rst),
        .ld     (cmd_fire && cmd_now.rd_load),
        .ld_val (addr_reg),
        .ld_arm (rd_arm_count(cmd_now)),
        .clr    (ctl_clear),
        .acc    (host_rd_acc),
        .adv    (1'b0),
        .ptr    (rd_ptr),
        .pend   (rd_pend),
        .hit    (rd_hit)
    );

    assign ram_we    = dma_valid || wr_hit;
    assign ram_wdata = dma_valid ? dma_data : host_wdata;

    adpcm_sample_ram #(.PW(PTR_W), .AW(RAM_AW), .DW(BYTE_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (wr_ptr),
        .wdata (ram_wdata),
        .re    (rd_hit),
        .raddr (rd_ptr),
        .rdata (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid   <= 1'b0;
            rd_dummy_q <= 1'b0;
        end else begin
            rd_valid   <= host_rd_acc;
            rd_dummy_q <= host_rd_acc && !rd_hit;
        end
    end

    assign rd_data     = rd_dummy_q ? '0 : ram_q;
    assign status      = pack_status(rd_pend != '0, wr_pend != '0, cmd_q.play);
    assign repeat_mode = cmd_q.rpt;
    assign play_req    = cmd_q.play;
    assign cmd_bits    = cmd_q;

endmodule

// File: rtl/adpcm_host_if_chk.sv
module adpcm_host_if_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_we,
    input logic       host_re,
    input logic [1:0] host_sel,
    input logic       c_b7,
    input logic       c_b3,
    input logic       c_b1,
    input logic       c_b0,
    input logic       dma_valid,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic       st_rd,
    input logic       st_play,
    input logic       st_wr,
    input logic       st_stop,
    input logic       cmd_strobe,
    input logic       seq_reset
);

    logic cmd_wr;
    logic data_rd;
    assign cmd_wr  = host_we && (host_sel == 2'd2);
    assign data_rd = host_re && (host_sel == 2'd3);

    always @(posedge clk) begin
        if (!rst) begin
            assert_stop_play_opposite_R8: assert (st_stop != st_play)
                else $error("stopped and playing bits agree");
        end
    end

    assert_wr_pend_armed_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && c_b1 && !c_b0) |=> st_wr);

    assert_rd_pend_armed_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && c_b3) |=> st_rd);

    assert_dummy_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (data_rd && st_rd) |=> (rd_valid && (rd_data == 8'h00)));

    assert_read_valid_R6: assert property (@(posedge clk) disable iff (rst)
        data_rd |=> rd_valid);

    assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (rst)
        !data_rd |=> !rd_valid);

    assert_dma_clears_wr_pend_R10: assert property (@(posedge clk) disable iff (rst)
        (dma_valid && !(cmd_wr && c_b1)) |=> !st_wr);

    assert_ctl_reset_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && c_b7) |=> seq_reset);

    assert_strobe_follows_R13: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> cmd_strobe);

    assert_strobe_single_R13: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr |=> !cmd_strobe);

endmodule

bind adpcm_host_if adpcm_host_if_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_we),
    .host_re    (host_re),
    .host_sel   (host_sel),
    .c_b7       (host_wdata[7]),
    .c_b3       (host_wdata[3]),
    .c_b1       (host_wdata[1]),
    .c_b0       (host_wdata[0]),
    .dma_valid  (dma_valid),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .st_rd      (status[7]),
    .st_play    (status[3]),
    .st_wr      (status[2]),
    .st_stop    (status[0]),
    .cmd_strobe (cmd_strobe),
    .seq_reset  (seq_reset)
);

// File: tb/test_adpcm_host_if.sv
module test_adpcm_host_if;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic        host_re = 1'b0;
    logic [1:0]  host_sel = 2'd0;
    logic [7:0]  host_wdata = 8'h00;
    logic        dma_valid = 1'b0;
    logic [7:0]  dma_data = 8'h00;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [7:0]  status;
    logic [15:0] play_len;
    logic        repeat_mode;
    logic        play_req;
    logic [15:0] play_start_ptr;
    logic [7:0]  cmd_bits;
    logic        cmd_strobe;
    logic        seq_reset;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      req_q[$];

    always #10 clk = ~clk;

    adpcm_host_if i_adpcm_host_if (
        .clk            (clk),
        .rst            (rst),
        .host_we        (host_we),
        .host_re        (host_re),
        .host_sel       (host_sel),
        .host_wdata     (host_wdata),
        .dma_valid      (dma_valid),
        .dma_data       (dma_data),
        .rd_valid       (rd_valid),
        .rd_data        (rd_data),
        .status         (status),
        .play_len       (play_len),
        .repeat_mode    (repeat_mode),
        .play_req       (play_req),
        .play_start_ptr (play_start_ptr),
        .cmd_bits       (cmd_bits),
        .cmd_strobe     (cmd_strobe),
        .seq_reset      (seq_reset)
    );

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: every read result is compared with the queued expectation.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check_eq("R6", "unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                logic [7:0] e;
                string      r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check_eq(r, "rd_data", {24'h0, rd_data}, {24'h0, e});
            end
        end
    end

    task automatic bus_wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic set_addr(input logic [15:0] a);
        bus_wr(2'd0, a[7:0]);
        bus_wr(2'd1, a[15:8]);
    endtask

    task automatic cmd(input logic [7:0] c);
        bus_wr(2'd2, c);
    endtask

    task automatic host_read(input logic [7:0] exp, input string req);
        @(negedge clk);
        host_re = 1'b1; host_sel = 2'd3;
        exp_q.push_back(exp);
        req_q.push_back(req);
        @(negedge clk);
        host_re = 1'b0;
    endtask

    task automatic dma(input logic [7:0] d);
        @(negedge clk);
        dma_valid = 1'b1; dma_data = d;
        @(negedge clk);
        dma_valid = 1'b0;
    endtask

    // Host write and DMA byte in the same cycle.
    task automatic bus_wr_with_dma(input logic [1:0] sel, input logic [7:0] d,
                                   input logic [7:0] dd);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        dma_valid = 1'b1; dma_data = dd;
        @(negedge clk);
        host_we = 1'b0; dma_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_eq("R1", "status", {24'h0, status}, 32'h01);
        check_eq("R1", "play_len", {16'h0, play_len}, 32'h0);
        check_eq("R1", "repeat/play", {30'h0, repeat_mode, play_req}, 32'h0);
        check_eq("R1", "strobes", {29'h0, rd_valid, cmd_strobe, seq_reset}, 32'h0);
        check_eq("R1", "play_start_ptr", {16'h0, play_start_ptr}, 32'h0);

        // R2/R3: write pointer load without pending, then fill
        set_addr(16'h0100);
        cmd(8'h03);
        check_eq("R3", "status no wr pending", {24'h0, status}, 32'h01);
        check_eq("R13", "cmd_strobe high", {31'h0, cmd_strobe}, 32'h1);
        check_eq("R13", "cmd_bits", {24'h0, cmd_bits}, 32'h03);
        @(negedge clk);
        check_eq("R13", "cmd_strobe single", {31'h0, cmd_strobe}, 32'h0);
        bus_wr(2'd3, 8'hA0);
        bus_wr(2'd3, 8'hA1);
        bus_wr(2'd3, 8'hA2);
        // R3 with one pending write, R5 discarded write
        set_addr(16'h0100);
        cmd(8'h02);
        check_eq("R3", "status wr pending", {24'h0, status}, 32'h05);
        bus_wr(2'd3, 8'hEE);
        check_eq("R5", "wr pending consumed", {24'h0, status}, 32'h01);
        bus_wr(2'd3, 8'hB0);

        // R4 two pending reads, R5 dummy data, R6 sequential reads
        set_addr(16'h0100);
        cmd(8'h08);
        check_eq("R4", "status rd pending", {24'h0, status}, 32'h81);
        host_read(8'h00, "R5");
        host_read(8'h00, "R5");
        check_eq("R5", "rd pending consumed", {24'h0, status}, 32'h01);
        host_read(8'hB0, "R6");
        host_read(8'hA1, "R6");
        host_read(8'hA2, "R2");
        // R4 one pending read
        set_addr(16'h0101);
        cmd(8'h0C);
        check_eq("R4", "status one rd pending", {24'h0, status}, 32'h81);
        host_read(8'h00, "R4");
        host_read(8'hA1, "R4");

        // R6 wrap from 0xFFFF to 0x0000
        set_addr(16'hFFFF);
        cmd(8'h03);
        bus_wr(2'd3, 8'hC1);
        bus_wr(2'd3, 8'hC2);
        set_addr(16'hFFFF);
        cmd(8'h0C);
        host_read(8'h00, "R6");
        host_read(8'hC1, "R6");
        host_read(8'hC2, "R6");

        // R7 length load and follow
        set_addr(16'h1234);
        cmd(8'h10);
        check_eq("R7", "play_len from cmd", {16'h0, play_len}, 32'h1234);
        bus_wr(2'd0, 8'h56);
        check_eq("R7", "play_len follows low", {16'h0, play_len}, 32'h1256);
        bus_wr(2'd1, 8'h9A);
        check_eq("R7", "play_len follows high", {16'h0, play_len}, 32'h9A56);
        cmd(8'h00);
        bus_wr(2'd0, 8'h78);
        check_eq("R7", "play_len held", {16'h0, play_len}, 32'h9A56);

        // R8 repeat / play / start pointer
        set_addr(16'h0300);
        cmd(8'h68);
        check_eq("R8", "status playing", {24'h0, status}, 32'h88);
        check_eq("R8", "repeat/play", {30'h0, repeat_mode, play_req}, 32'h3);
        check_eq("R8", "start ptr new load", {16'h0, play_start_ptr}, 32'h0300);
        cmd(8'h00);
        check_eq("R8", "status stopped", {24'h0, status}, 32'h81);
        check_eq("R8", "repeat/play off", {30'h0, repeat_mode, play_req}, 32'h0);
        set_addr(16'h0500);
        cmd(8'h40);
        check_eq("R8", "start ptr from rptr", {16'h0, play_start_ptr}, 32'h0300);

        // R9 controller reset
        set_addr(16'h0200);
        cmd(8'h02);
        check_eq("R9", "status before reset", {24'h0, status}, 32'h85);
        cmd(8'h80);
        check_eq("R9", "status after reset", {24'h0, status}, 32'h01);
        check_eq("R9", "seq_reset pulse", {31'h0, seq_reset}, 32'h1);
        check_eq("R9", "start ptr cleared", {16'h0, play_start_ptr}, 32'h0);
        @(negedge clk);
        check_eq("R9", "seq_reset single", {31'h0, seq_reset}, 32'h0);
        bus_wr(2'd3, 8'hD5);
        host_read(8'hD5, "R9");
        set_addr(16'h0040);
        cmd(8'h8B);
        check_eq("R9", "loads after clear", {24'h0, status}, 32'h81);
        bus_wr(2'd3, 8'hE1);
        host_read(8'h00, "R9");
        host_read(8'h00, "R9");
        host_read(8'hE1, "R9");

        // R10 DMA
        set_addr(16'h0080);
        cmd(8'h02);
        dma(8'h11);
        check_eq("R10", "dma clears wr pending", {24'h0, status}, 32'h01);
        dma(8'h22);
        set_addr(16'h0080);
        cmd(8'h0C);
        host_read(8'h00, "R10");
        host_read(8'h11, "R10");
        host_read(8'h22, "R10");

        // R11 DMA with write-pointer load in the same cycle
        set_addr(16'h0090);
        cmd(8'h03);
        dma(8'h33);
        set_addr(16'h00A0);
        bus_wr_with_dma(2'd2, 8'h02, 8'h44);
        check_eq("R11", "load wins pending", {24'h0, status}, 32'h05);
        dma(8'h55);
        set_addr(16'h0090);
        cmd(8'h0C);
        host_read(8'h00, "R11");
        host_read(8'h33, "R11");
        host_read(8'h44, "R11");
        set_addr(16'h00A0);
        cmd(8'h0C);
        host_read(8'h00, "R11");
        host_read(8'h55, "R11");

        // R12 host data write colliding with DMA
        set_addr(16'h00B0);
        cmd(8'h03);
        bus_wr_with_dma(2'd3, 8'h66, 8'h77);
        bus_wr(2'd3, 8'h88);
        set_addr(16'h00C0);
        cmd(8'h02);
        bus_wr_with_dma(2'd3, 8'h5A, 8'h6B);
        check_eq("R12", "status after collision", {24'h0, status}, 32'h01);
        bus_wr(2'd3, 8'h7C);
        set_addr(16'h00B0);
        cmd(8'h0C);
        host_read(8'h00, "R12");
        host_read(8'h77, "R12");
        host_read(8'h88, "R12");
        set_addr(16'h00C0);
        cmd(8'h0C);
        host_read(8'h00, "R12");
        host_read(8'h6B, "R12");
        host_read(8'h7C, "R12");

        repeat (3) @(negedge clk);
        check_eq("R6", "reads outstanding", exp_q.size(), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule